// File: doc/BRIEF.md
# Audio Controller Interrupt Aggregator

This block owns the 32-bit interrupt control register of an audio controller and reduces every interrupt source of the controller to a single level-sensitive interrupt request. Four input and four output DMA streams each report two status conditions. One is completion of a buffer whose descriptor asked for an interrupt. The other is a FIFO underrun or overrun. The controller itself reports three events: a response was received, the response buffer overran, and a codec changed state.

Gating has two levels. A global enable sits above everything. Below it, one controller enable covers the three controller events, and one enable bit per stream covers that stream's status. The status bits are inputs here; their clear logic lives elsewhere. A pulse on the power-wake input marks a return from the low-power hot state to the active state. With the default configuration every implemented enable keeps its value across that transition, so only the asynchronous reset clears the register.

Top module: `audio_irq_aggregator`

## Requirements
- R1: After reset the register reads 0x00000000 and `irq_o` is 0.
- R2: Bits 29:8 always read 0, and the values written to them have no effect on readback or on `irq_o`.
- R3: When bit 31 (global enable) is 0, `irq_o` is 0 whatever the sources and the other enables are.
- R4: With bits 31 and 30 set, any one of `rsp_irq_sts_i`, `rsp_ovf_sts_i` or `state_chg_sts_i` raises `irq_o`. With bit 30 clear, none of them does.
- R5: Enable bit k (k = 0..3) gates input stream k+1 (index k of the `in_*` inputs). Enable bit 4+k gates output stream k+1 (index k of the `out_*` inputs). A stream with its bit clear never raises `irq_o`, and its bit has no effect on other streams.
- R6: A stream's status is the OR of its buffer-done input and its FIFO-error input, and either one alone raises `irq_o` when enabled.
- R7: `irq_o` is registered. It reflects the register and the sources sampled on the previous rising edge, stays high while an enabled source stays high, and falls one edge after the last such source falls.
- R8: A `pwr_wake_i` pulse leaves bits 31, 30 and 7:0 unchanged, and `irq_o` is unchanged with it.
- R9: A write with `wr_en_i` high loads bits 31, 30 and 7:0 from `wr_data_i`, visible on `rd_data_o` from the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 32 | Register write data |
| rd_data_o | output | 32 | Register readback |
| in_buf_done_i | input | 4 | Input stream buffer-complete status |
| in_fifo_err_i | input | 4 | Input stream FIFO error status |
| out_buf_done_i | input | 4 | Output stream buffer-complete status |
| out_fifo_err_i | input | 4 | Output stream FIFO error status |
| rsp_irq_sts_i | input | 1 | Response received status |
| rsp_ovf_sts_i | input | 1 | Response buffer overrun status |
| state_chg_sts_i | input | 1 | Codec state change status |
| pwr_wake_i | input | 1 | Power transition hot-low-power to active, one-cycle pulse |
| irq_o | output | 1 | Level interrupt request |

## Verification
A wrong enable bit or a swapped stream index inside the block shows at the ports within one edge. The stuck or misplaced bit appears at once on `rd_data_o`, and `irq_o` rises for the wrong source, or fails to rise, on the edge after the source goes high. The bench sweeps all 1024 enable patterns against every single source, so each stuck, swapped or cross-wired gate term produces a mismatch. A register cleared by the wake pulse shows on readback in the next cycle, and it also shows as a lost `irq_o`.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned REG_W      = 32;
  localparam int unsigned GIE_POS    = 31;
  localparam int unsigned CIE_POS    = 30;
  localparam int unsigned N_IN_STRM  = 4;
  localparam int unsigned N_OUT_STRM = 4;
  localparam int unsigned N_CTL_EVT  = 3;

  typedef enum logic [1:0] {
    EVT_RSP   = 2'd0,
    EVT_OVF   = 2'd1,
    EVT_STATE = 2'd2
  } ctl_evt_e;
endpackage

// File: rtl/irq_ctl_reg.sv
module irq_ctl_reg
  import irq_agg_pkg::*;
#(
  parameter int unsigned N_STRM    = 8,
  parameter bit          WAKE_KEEP = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [REG_W-1:0]  wr_data_i,
  input  logic              wake_i,
  output logic              gie_o,
  output logic              cie_o,
  output logic [N_STRM-1:0] sie_o,
  output logic [REG_W-1:0]  rd_data_o
);
  logic              gie_q, cie_q;
  logic [N_STRM-1:0] sie_q, sie_d;
  logic              unused_rsvd;

  assign unused_rsvd = ^wr_data_i[CIE_POS-1:N_STRM];

  // stream enables optionally cleared by wake; global and controller enables never
  always_comb begin
    if (wr_en_i)                sie_d = wr_data_i[N_STRM-1:0];
    else if (wake_i && !WAKE_KEEP) sie_d = '0;
    else                        sie_d = sie_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gie_q <= 1'b0;
      cie_q <= 1'b0;
      sie_q <= '0;
    end else begin
      if (wr_en_i) begin
        gie_q <= wr_data_i[GIE_POS];
        cie_q <= wr_data_i[CIE_POS];
      end
      sie_q <= sie_d;
    end
  end

  always_comb begin
    rd_data_o                = '0;
    rd_data_o[GIE_POS]       = gie_q;
    rd_data_o[CIE_POS]       = cie_q;
    rd_data_o[N_STRM-1:0]    = sie_q;
  end

  assign gie_o = gie_q;
  assign cie_o = cie_q;
  assign sie_o = sie_q;
endmodule

// File: rtl/irq_strm_gate.sv
module irq_strm_gate #(
  parameter int unsigned N_STRM = 8
) (
  input  logic [N_STRM-1:0] sie_i,
  input  logic [N_STRM-1:0] buf_done_i,
  input  logic [N_STRM-1:0] fifo_err_i,
  output logic              hit_o
);
  logic [N_STRM-1:0] gated;

  for (genvar s = 0; s < N_STRM; s++) begin : g_strm
    assign gated[s] = sie_i[s] & (buf_done_i[s] | fifo_err_i[s]);
  end

  assign hit_o = |gated;
endmodule

// File: rtl/irq_merge.sv
module irq_merge
  import irq_agg_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 gie_i,
  input  logic                 cie_i,
  input  logic [N_CTL_EVT-1:0] ctl_evt_i,
  input  logic                 strm_hit_i,
  output logic                 irq_o
);
  logic ctl_hit, irq_d, irq_q;

  assign ctl_hit = cie_i & (|ctl_evt_i);
  assign irq_d   = gie_i & (ctl_hit | strm_hit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= irq_d;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/audio_irq_aggregator.sv
module audio_irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int unsigned N_IN      = N_IN_STRM,
  parameter int unsigned N_OUT     = N_OUT_STRM,
  parameter bit          WAKE_KEEP = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [31:0]      wr_data_i,
  output logic [31:0]      rd_data_o,
  input  logic [N_IN-1:0]  in_buf_done_i,
  input  logic [N_IN-1:0]  in_fifo_err_i,
  input  logic [N_OUT-1:0] out_buf_done_i,
  input  logic [N_OUT-1:0] out_fifo_err_i,
  input  logic             rsp_irq_sts_i,
  input  logic             rsp_ovf_sts_i,
  input  logic             state_chg_sts_i,
  input  logic             pwr_wake_i,
  output logic             irq_o
);
  localparam int unsigned N_STRM = N_IN + N_OUT;

  logic                 gie, cie, strm_hit;
  logic [N_STRM-1:0]    sie, strm_done, strm_ferr;
  logic [N_CTL_EVT-1:0] ctl_evt;

  // input streams occupy the low enable bits
  assign strm_done = {out_buf_done_i, in_buf_done_i};
  assign strm_ferr = {out_fifo_err_i, in_fifo_err_i};

  always_comb begin
    ctl_evt            = '0;
    ctl_evt[EVT_RSP]   = rsp_irq_sts_i;
    ctl_evt[EVT_OVF]   = rsp_ovf_sts_i;
    ctl_evt[EVT_STATE] = state_chg_sts_i;
  end

  irq_ctl_reg #(.N_STRM(N_STRM), .WAKE_KEEP(WAKE_KEEP)) i_ctl_reg (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i,
    .wake_i(pwr_wake_i), .gie_o(gie), .cie_o(cie), .sie_o(sie), .rd_data_o
  );

  irq_strm_gate #(.N_STRM(N_STRM)) i_strm_gate (
    .sie_i(sie), .buf_done_i(strm_done), .fifo_err_i(strm_ferr), .hit_o(strm_hit)
  );

  irq_merge i_merge (
    .clk_i, .rst_ni, .gie_i(gie), .cie_i(cie), .ctl_evt_i(ctl_evt),
    .strm_hit_i(strm_hit), .irq_o
  );
endmodule

// File: rtl/audio_irq_aggregator_chk.sv
module audio_irq_aggregator_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic [31:0] rd_data_o,
  input logic [3:0]  in_buf_done_i,
  input logic [3:0]  in_fifo_err_i,
  input logic [3:0]  out_buf_done_i,
  input logic [3:0]  out_fifo_err_i,
  input logic        rsp_irq_sts_i,
  input logic        rsp_ovf_sts_i,
  input logic        state_chg_sts_i,
  input logic        pwr_wake_i,
  input logic        irq_o
);
  logic any_src;
  assign any_src = rsp_irq_sts_i | rsp_ovf_sts_i | state_chg_sts_i |
                   (|in_buf_done_i) | (|in_fifo_err_i) | (|out_buf_done_i) | (|out_fifo_err_i);

  p_rsvd_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[29:8] == '0);

  p_gie_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_data_o[31] |=> !irq_o);

  p_ctl_evt_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o[31] && rd_data_o[30] && (rsp_irq_sts_i || rsp_ovf_sts_i || state_chg_sts_i)) |=> irq_o);

  p_in1_gate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o[31] && rd_data_o[0] && (in_buf_done_i[0] || in_fifo_err_i[0])) |=> irq_o);

  p_out4_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o[31] && rd_data_o[7] && (out_buf_done_i[3] || out_fifo_err_i[3])) |=> irq_o);

  p_no_src_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !any_src |=> !irq_o);

  p_wake_keep_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_wake_i && !wr_en_i) |=> $stable(rd_data_o));
endmodule

bind audio_irq_aggregator audio_irq_aggregator_chk i_chk (
  .clk_i, .rst_ni, .wr_en_i, .rd_data_o, .in_buf_done_i, .in_fifo_err_i,
  .out_buf_done_i, .out_fifo_err_i, .rsp_irq_sts_i, .rsp_ovf_sts_i,
  .state_chg_sts_i, .pwr_wake_i, .irq_o
);

// File: tb/test_audio_irq_aggregator.sv
module test_audio_irq_aggregator;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [3:0]  in_done = '0, in_ferr = '0, out_done = '0, out_ferr = '0;
  logic        rsp = 1'b0, ovf = 1'b0, stc = 1'b0, wake = 1'b0;
  logic        irq;
  int          checks = 0, failures = 0;

  always #2 clk = ~clk;

  audio_irq_aggregator i_audio_irq_aggregator (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_data_o(rd_data),
    .in_buf_done_i(in_done), .in_fifo_err_i(in_ferr), .out_buf_done_i(out_done),
    .out_fifo_err_i(out_ferr), .rsp_irq_sts_i(rsp), .rsp_ovf_sts_i(ovf),
    .state_chg_sts_i(stc), .pwr_wake_i(wake), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] v);
    @(negedge clk); wr_en = 1'b1; wr_data = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  // 0 none, 1..3 controller events, 4..11 buffer done stream, 12..19 fifo error stream
  task automatic set_src(input int s, input logic v);
    rsp = 1'b0; ovf = 1'b0; stc = 1'b0;
    in_done = '0; in_ferr = '0; out_done = '0; out_ferr = '0;
    if (v) begin
      case (s)
        1: rsp = 1'b1;
        2: ovf = 1'b1;
        3: stc = 1'b1;
        default: begin
          if (s >= 4 && s < 8)        in_done[s-4]   = 1'b1;
          else if (s >= 8 && s < 12)  out_done[s-8]  = 1'b1;
          else if (s >= 12 && s < 16) in_ferr[s-12]  = 1'b1;
          else if (s >= 16 && s < 20) out_ferr[s-16] = 1'b1;
        end
      endcase
    end
  endtask

  function automatic logic exp_irq(input logic [31:0] c, input int s);
    logic hit;
    if (s == 0)     hit = 1'b0;
    else if (s < 4) hit = c[30];
    else            hit = c[(s - 4) % 8];
    return c[31] & hit;
  endfunction

  function automatic logic [31:0] impl(input logic [31:0] v);
    return v & 32'hC000_00FF;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] ctl;
    repeat (3) @(negedge clk);
    chk("R1 reset readback", rd_data, 32'h0);
    chk("R1 reset irq", {31'h0, irq}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    set_src(1, 1'b1);
    @(negedge clk);
    chk("R1 R3 disabled after reset", {31'h0, irq}, 32'h0);
    set_src(0, 1'b0);

    // exhaustive sweep: enable pattern x single source
    for (int p = 0; p < 1024; p++) begin
      ctl = {p[9], p[8], 22'(p * 32'h2D5 + 32'h1357), p[7:0]};
      wr(ctl);
      chk("R2 R9 readback", rd_data, impl(ctl));
      for (int s = 0; s < 20; s++) begin
        set_src(s, 1'b1);
        @(negedge clk);
        chk($sformatf("R3 R4 R5 R6 ctl=%h src=%0d", ctl, s), {31'h0, irq}, {31'h0, exp_irq(ctl, s)});
        set_src(s, 1'b0);
        @(negedge clk);
      end
    end

    // R7 latency and level behaviour
    wr(32'h8000_0004);
    @(negedge clk);
    in_done[2] = 1'b1;
    #1 chk("R7 no combinational path", {31'h0, irq}, 32'h0);
    @(negedge clk);
    chk("R7 rises after one edge", {31'h0, irq}, 32'h1);
    repeat (3) @(negedge clk);
    chk("R7 level held", {31'h0, irq}, 32'h1);
    in_done[2] = 1'b0;
    #1 chk("R7 still high before edge", {31'h0, irq}, 32'h1);
    @(negedge clk);
    chk("R7 falls after one edge", {31'h0, irq}, 32'h0);

    // R8 wake keeps enables and interrupt
    wr(32'hFFFF_FFFF);
    out_ferr[1] = 1'b1;
    @(negedge clk);
    wake = 1'b1;
    @(negedge clk);
    wake = 1'b0;
    chk("R8 readback after wake", rd_data, 32'hC000_00FF);
    @(negedge clk);
    chk("R8 irq after wake", {31'h0, irq}, 32'h1);
    out_ferr[1] = 1'b0;
    wr(32'h4000_0010);
    wake = 1'b1;
    @(negedge clk);
    wake = 1'b0;
    chk("R8 partial pattern after wake", rd_data, 32'h4000_0010);

    // R2 reserved-only write clears implemented bits, reserved stay 0
    wr(32'h3FFF_FF00);
    chk("R2 reserved-only write", rd_data, 32'h0);
    out_done[0] = 1'b1;
    @(negedge clk);
    chk("R2 reserved no irq effect", {31'h0, irq}, 32'h0);
    out_done[0] = 1'b0;

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule